// File: doc/BRIEF.md
# Pipelined Work-Efficient Scan Unit

The unit takes a vector of `N_LANES` unsigned values of `DATA_W` bits each, qualified by a valid strobe. A fixed number of cycles later it returns the running totals of that vector, qualified by a matching valid strobe. Output lane i combines input lanes 0 through i. The combining operator is chosen by a parameter: addition modulo 2^`DATA_W` or bitwise XOR. A second parameter moves every result up by one lane, so lane i combines lanes 0 through i-1 and lane 0 carries the identity value. This gives an exclusive scan.

The network works in three phases. It first combines neighbouring pairs, then scans the pair results recursively, and finally fixes up the even lanes. It has 2·log2(N_LANES) − 2 combining levels, and each level is one register stage. The pipeline has no stall and accepts a new vector on every cycle. Each vector is scanned on its own: no value carries over from one vector to the next. The caller must take each result in the cycle it is flagged valid.

Top module: `prefix_scan_top`

## Requirements
- R1: When `valid_o` is high in inclusive mode, lane i of `data_o` equals the operator applied over input lanes 0..i of the matching input vector. Lane i occupies bits [i*DATA_W +: DATA_W].
- R2: In inclusive mode, output lane 0 equals input lane 0 of the matching vector.
- R3: `valid_o` rises exactly 2·log2(N_LANES) − 2 cycles after the cycle in which `valid_i` was high. That is 6 cycles for 16 lanes and 4 cycles for 8 lanes.
- R4: Vectors presented on consecutive cycles each produce exactly one result, in order, on consecutive cycles. No vector is dropped and none is duplicated.
- R5: With the add operator (OP_ADD, code 0), all sums wrap modulo 2^DATA_W and no carry is reported.
- R6: With EXCLUSIVE=1, output lane 0 is 0 and lane i (i ≥ 1) equals the operator over input lanes 0..i-1.
- R7: While `valid_o` is low, `data_o` holds its previous value. Input data presented with `valid_i` low has no effect on any later output.
- R8: With the XOR operator (OP_XOR, code 1), each lane combines its predecessors by bitwise XOR instead of addition.
- R9: During reset, `valid_o` is 0 and every bit of `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector qualifier |
| data_i | input | N_LANES*DATA_W | Input lanes, lane 0 in the least significant bits |
| valid_o | output | 1 | Result qualifier |
| data_o | output | N_LANES*DATA_W | Scan results, lane 0 in the least significant bits |

## Verification
The hardest case to reach from the ports is wrap-around in every lane at once while the pipeline is completely full. In that case no idle cycle separates one vector's high lanes from the next vector's low lanes in the same register. The bench reaches it by streaming 256 back-to-back vectors whose lanes all hold the same value, sweeping that value across every 8-bit code. It then streams a long pseudo-random run with idle gaps that carry junk data, which checks that results stay held and that gap data leaves no trace. A second instance with 8 lanes, the XOR operator and exclusive output receives the low bits of the same stimulus.

// File: rtl/prefix_scan_pkg.sv
package prefix_scan_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_XOR = 2'd1
  } scan_op_e;

  // Lane whose value lane j absorbs at combining level s (1-based), or -1.
  // Levels 1..lg-1 reduce pairs; level lg also closes the grand total while
  // starting the fix-up; the remaining levels fill in the gaps at finer strides.
  function automatic int partner_lane(int s, int j, int lg);
    int d;
    int p;
    p = -1;
    if (s <= lg - 1) begin
      d = s;
      if (((j + 1) % (1 << d)) == 0) p = j - (1 << (d - 1));
    end else begin
      d = 2 * lg - 1 - s;
      if (j >= (1 << d) && ((j + 1) % (1 << d)) == (1 << (d - 1)))
        p = j - (1 << (d - 1));
      if (s == lg && j == (1 << lg) - 1) p = j - (1 << (lg - 1));
    end
    return p;
  endfunction

endpackage

// File: rtl/prefix_scan_stage.sv
module prefix_scan_stage
  import prefix_scan_pkg::*;
#(
  parameter int       N_LANES = 16,
  parameter int       DATA_W  = 16,
  parameter scan_op_e OP      = OP_ADD,
  parameter int       STAGE   = 1,
  parameter int       LG      = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [N_LANES*DATA_W-1:0] data_i,
  output logic                      valid_o,
  output logic [N_LANES*DATA_W-1:0] data_o
);

  logic [N_LANES*DATA_W-1:0] nxt;

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    localparam int P = partner_lane(STAGE, j, LG);
    if (P >= 0) begin : g_op
      if (OP == OP_XOR) begin : g_xor
        assign nxt[j*DATA_W +: DATA_W] = data_i[j*DATA_W +: DATA_W] ^ data_i[P*DATA_W +: DATA_W];
      end else begin : g_add
        assign nxt[j*DATA_W +: DATA_W] = data_i[j*DATA_W +: DATA_W] + data_i[P*DATA_W +: DATA_W];
      end
    end else begin : g_pass
      assign nxt[j*DATA_W +: DATA_W] = data_i[j*DATA_W +: DATA_W];
    end
  end

  // data loads only with a valid vector so idle cycles leave results held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= nxt;
    end
  end

endmodule

// File: rtl/prefix_scan_outsel.sv
module prefix_scan_outsel #(
  parameter int N_LANES   = 16,
  parameter int DATA_W    = 16,
  parameter bit EXCLUSIVE = 1'b0
) (
  input  logic [N_LANES*DATA_W-1:0] incl_i,
  output logic [N_LANES*DATA_W-1:0] data_o
);

  if (EXCLUSIVE) begin : g_excl
    logic [DATA_W-1:0] unused_top_lane;
    assign unused_top_lane = incl_i[N_LANES*DATA_W-1 -: DATA_W];
    // identity is zero for both supported operators
    assign data_o = {incl_i[(N_LANES-1)*DATA_W-1:0], {DATA_W{1'b0}}};
  end else begin : g_incl
    assign data_o = incl_i;
  end

endmodule

// File: rtl/prefix_scan_top.sv
module prefix_scan_top
  import prefix_scan_pkg::*;
#(
  parameter int       N_LANES   = 16,
  parameter int       DATA_W    = 16,
  parameter scan_op_e OP        = OP_ADD,
  parameter bit       EXCLUSIVE = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [N_LANES*DATA_W-1:0] data_i,
  output logic                      valid_o,
  output logic [N_LANES*DATA_W-1:0] data_o
);

  localparam int LG    = $clog2(N_LANES);
  localparam int DEPTH = 2 * LG - 2;

  logic [N_LANES*DATA_W-1:0] stg_d [DEPTH+1];
  logic [DEPTH:0]            stg_v;

  assign stg_d[0] = data_i;
  assign stg_v[0] = valid_i;

  for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
    prefix_scan_stage #(
      .N_LANES(N_LANES),
      .DATA_W (DATA_W),
      .OP     (OP),
      .STAGE  (s),
      .LG     (LG)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(stg_v[s-1]),
      .data_i (stg_d[s-1]),
      .valid_o(stg_v[s]),
      .data_o (stg_d[s])
    );
  end

  prefix_scan_outsel #(
    .N_LANES  (N_LANES),
    .DATA_W   (DATA_W),
    .EXCLUSIVE(EXCLUSIVE)
  ) u_outsel (
    .incl_i(stg_d[DEPTH]),
    .data_o(data_o)
  );

  assign valid_o = stg_v[DEPTH];

endmodule

// File: rtl/prefix_scan_chk.sv
module prefix_scan_chk
  import prefix_scan_pkg::*;
#(
  parameter int       N_LANES   = 16,
  parameter int       DATA_W    = 16,
  parameter scan_op_e OP        = OP_ADD,
  parameter bit       EXCLUSIVE = 1'b0
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      valid_i,
  input logic [N_LANES*DATA_W-1:0] data_i,
  input logic                      valid_o,
  input logic [N_LANES*DATA_W-1:0] data_o
);

  localparam int LG    = $clog2(N_LANES);
  localparam int DEPTH = 2 * LG - 2;
  localparam int W     = DATA_W;

  function automatic logic [W-1:0] comb(input logic [W-1:0] a, input logic [W-1:0] b);
    return (OP == OP_XOR) ? (a ^ b) : (a + b);
  endfunction

  logic [W-1:0] tot_now;
  always_comb begin
    tot_now = '0;
    for (int i = 0; i < N_LANES; i++) tot_now = comb(tot_now, data_i[i*W +: W]);
  end

  logic [DEPTH-1:0] vm;
  logic [W-1:0]     l0_p   [DEPTH];
  logic [W-1:0]     last_p [DEPTH];
  logic [W-1:0]     tot_p  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vm <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        l0_p[k]   <= '0;
        last_p[k] <= '0;
        tot_p[k]  <= '0;
      end
    end else begin
      vm        <= {vm[DEPTH-2:0], valid_i};
      l0_p[0]   <= data_i[W-1:0];
      last_p[0] <= data_i[N_LANES*W-1 -: W];
      tot_p[0]  <= tot_now;
      for (int k = 1; k < DEPTH; k++) begin
        l0_p[k]   <= l0_p[k-1];
        last_p[k] <= last_p[k-1];
        tot_p[k]  <= tot_p[k-1];
      end
    end
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vm[DEPTH-1]);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  if (!EXCLUSIVE) begin : g_incl
    assert_lane0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> data_o[W-1:0] == l0_p[DEPTH-1]);
    assert_total_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> data_o[N_LANES*W-1 -: W] == tot_p[DEPTH-1]);
    assert_last_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> comb(data_o[(N_LANES-1)*W-1 -: W], last_p[DEPTH-1]) == data_o[N_LANES*W-1 -: W]);
  end else begin : g_excl
    assert_lane0_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> data_o[W-1:0] == '0);
    assert_lane1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> data_o[2*W-1 -: W] == l0_p[DEPTH-1]);
    assert_total_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> comb(data_o[N_LANES*W-1 -: W], last_p[DEPTH-1]) == tot_p[DEPTH-1]);
  end

endmodule

bind prefix_scan_top prefix_scan_chk #(
  .N_LANES  (N_LANES),
  .DATA_W   (DATA_W),
  .OP       (OP),
  .EXCLUSIVE(EXCLUSIVE)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .data_i (data_i),
  .valid_o(valid_o),
  .data_o (data_o)
);

// File: tb/prefix_scan_top_test.sv
module prefix_scan_top_test;
  import prefix_scan_pkg::*;

  localparam int CLK_P = 10;
  localparam int NA = 16, WA = 8, DA = 2 * $clog2(NA) - 2;
  localparam int NB = 8,  WB = 4, DB = 2 * $clog2(NB) - 2;
  localparam int QD = 32;
  localparam int VW = NA * WA;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [VW-1:0] din = '0;
  logic va, vb;
  logic [VW-1:0] da;
  logic [NB*WB-1:0] db;

  int n_chk = 0, n_bad = 0, cyc = 0, wr = 0, rd_a = 0, rd_b = 0;
  logic [VW-1:0] q_data [QD];
  int q_cyc [QD];
  logic [VW-1:0] last_a = '0;
  logic [NB*WB-1:0] last_b = '0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  prefix_scan_top #(.N_LANES(NA), .DATA_W(WA), .OP(OP_ADD), .EXCLUSIVE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .data_i(din), .valid_o(va), .data_o(da));

  prefix_scan_top #(.N_LANES(NB), .DATA_W(WB), .OP(OP_XOR), .EXCLUSIVE(1'b1)) uut_x (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .data_i(din[NB*WB-1:0]), .valid_o(vb), .data_o(db));

  function automatic logic [VW-1:0] exp_a(input logic [VW-1:0] x);
    logic [WA-1:0] acc = '0;
    logic [VW-1:0] r = '0;
    for (int i = 0; i < NA; i++) begin
      acc = acc + x[i*WA +: WA];
      r[i*WA +: WA] = acc;
    end
    return r;
  endfunction

  function automatic logic [NB*WB-1:0] exp_b(input logic [NB*WB-1:0] x);
    logic [WB-1:0] acc = '0;
    logic [NB*WB-1:0] r = '0;
    for (int i = 0; i < NB; i++) begin
      r[i*WB +: WB] = acc;
      acc = acc ^ x[i*WB +: WB];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard: record every accepted vector and the cycle it was taken
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && vld) begin
      q_data[wr % QD] <= din;
      q_cyc[wr % QD]  <= cyc;
      wr <= wr + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (va) begin
        if (rd_a == wr) check(1'b0, "R4", "surplus result A", da, '0);
        else begin
          check(da == exp_a(q_data[rd_a % QD]), "R1 R5", "inclusive sums", da, exp_a(q_data[rd_a % QD]));
          check(da[WA-1:0] == q_data[rd_a % QD][WA-1:0], "R2", "lane0 pass", VW'(da[WA-1:0]),
                VW'(q_data[rd_a % QD][WA-1:0]));
          check(cyc - q_cyc[rd_a % QD] == DA, "R3", "latency A", VW'(cyc - q_cyc[rd_a % QD]), VW'(DA));
          rd_a++;
        end
        last_a = da;
      end else begin
        check(da == last_a, "R7", "held A", da, last_a);
      end
      if (vb) begin
        if (rd_b == wr) check(1'b0, "R4", "surplus result B", VW'(db), '0);
        else begin
          check(db == exp_b(q_data[rd_b % QD][NB*WB-1:0]), "R6 R8", "exclusive xor scan",
                VW'(db), VW'(exp_b(q_data[rd_b % QD][NB*WB-1:0])));
          check(cyc - q_cyc[rd_b % QD] == DB, "R3", "latency B", VW'(cyc - q_cyc[rd_b % QD]), VW'(DB));
          rd_b++;
        end
        last_b = db;
      end else begin
        check(db == last_b, "R7", "held B", VW'(db), VW'(last_b));
      end
    end
  end

  task automatic drive(input bit v, input logic [VW-1:0] d);
    vld = v;
    din = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, {(VW/32){32'hDEAD_BEEF ^ 32'(k)}});
  endtask

  function automatic logic [31:0] xs32(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual run still active expected completion");
    finish_run();
  end

  initial begin
    logic [VW-1:0] vec;
    repeat (3) @(negedge clk);
    check(!va && da == '0, "R9", "reset state A", {da[VW-2:0], va}, '0);
    check(!vb && db == '0, "R9", "reset state B", VW'({db, vb}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // ramp 1..16
    vec = '0;
    for (int i = 0; i < NA; i++) vec[i*WA +: WA] = WA'(i + 1);
    drive(1'b1, vec);
    idle(DA + 2);

    // every lane at maximum: wraps from lane 1 upward (R5)
    drive(1'b1, {VW{1'b1}});
    idle(3);

    // back-to-back sweep of all 8-bit lane values (R4, R5)
    for (int v = 0; v < 256; v++) drive(1'b1, {NA{8'(v)}});
    idle(2);

    // pseudo-random stream with junk-carrying gaps (R7)
    for (int k = 0; k < 300; k++) begin
      for (int w = 0; w < VW / 32; w++) begin
        rng = xs32(rng);
        vec[w*32 +: 32] = rng;
      end
      drive((k % 7) != 3, vec);
    end

    // single active lane at each position
    for (int k = 0; k < NA; k++) begin
      vec = '0;
      vec[k*WA +: WA] = WA'(k * 17 + 1);
      drive(1'b1, vec);
    end

    idle(DA + 4);
    check(rd_a == wr, "R4", "results A vs accepted", VW'(rd_a), VW'(wr));
    check(rd_b == wr, "R4", "results B vs accepted", VW'(rd_b), VW'(wr));
    done = 1'b1;
    finish_run();
  end

endmodule